// File: doc/BRIEF.md
# Three-Output Shared-Period PWM Channel

This block is one timer channel that turns a single up-counter into several pulse-width-modulated pins that share one period. A period-compare value fixes how many count ticks one period spans; each pin has its own duty-compare value that decides where in the period the pin toggles. Every pin can be flipped between active-high and active-low, can begin each run at either its active or its inactive level, and can be released to high impedance through its own output-enable.

The counter advances only on cycles where the count-enable input is high, which lets a prescaler or any other tick generator act as the count source. A rising edge on the start input restarts the run from zero with every pin at its starting level. Software programs the channel and clears match flags through a small write-only register port; the four compare values each own a sticky match flag that the hardware sets.

Top module: `pwm_chan`

## Requirements
- R1: The counter rises by one on each cycle where start is high (and was high in the previous cycle) and count-enable is high; on every other cycle, outside a restart, it holds its value.
- R2: The period value lives at address 0; when the counter equals the period value on an advancing cycle it returns to zero, so one period lasts period+1 ticks.
- R3: The duty value of pin i lives at address 1+i; with duty n and period m (n < m) the pin holds its starting level for n+1 ticks after the counter leaves zero-start and holds the opposite level for the remaining m-n ticks.
- R4: Control word at address 4, bits [5:3], is the per-pin polarity: 1 makes the active level high, 0 makes it low; a change acts on the pin on the next cycle.
- R5: Control word bits [8:6] select the starting level per pin: 1 starts at the active level, 0 at the inactive level.
- R6: A duty value greater than or equal to the period value keeps that pin at its starting level for the whole period.
- R7: Flag bit 0 belongs to the period compare and flag bit 1+i to the duty compare of pin i; a flag becomes 1 on an advancing cycle where the counter equals its compare value and stays 1 until a write to address 5 carries 0 in that bit; writing 1 leaves it unchanged.
- R8: When a flag-clear write and a hardware set land on the same cycle, the flag ends up set.
- R9: Control word bits [2:0] are the per-pin enables; a pin's output-enable follows its enable bit from the cycle after the write.
- R10: A rising edge on start forces the counter to zero and every pin to its starting level on the next cycle, whatever count-enable does.
- R11: After reset the counter is zero, all flags are zero and all output-enables are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Channel run control; rising edge restarts |
| cnt_en_i | input | 1 | Count-source tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | CNT_W (16) | Register write data |
| pwm_o | output | NUM_OUT (3) | Pin levels |
| pwm_oe_o | output | NUM_OUT (3) | Pin output-enables, 0 means high impedance |
| flag_o | output | NUM_OUT+1 (4) | Sticky compare-match flags |
| cnt_o | output | CNT_W (16) | Current counter value |

## Verification
On every cycle the assertions watch the counter's step-or-hold rule, its return to zero after a period match, the zero after a start edge, the stickiness of the flags between flag writes, the precedence of a hardware set over a clear, and the output-enables after a control write. The pin waveforms themselves (length of the starting phase, the effect of polarity and starting level, a duty at or above the period) and the exact cycle on which a clear write collides with a period match are shown only by the bench's directed scenarios, which compare each pin tick by tick against the expected shape.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

   typedef logic [3:0] reg_addr_t;

   localparam reg_addr_t ADDR_PERIOD = 4'd0;

   function automatic reg_addr_t duty_addr(input int unsigned idx);
      return reg_addr_t'(idx + 1);
   endfunction

   function automatic reg_addr_t ctrl_addr(input int unsigned n_out);
      return reg_addr_t'(n_out + 1);
   endfunction

   function automatic reg_addr_t flag_addr(input int unsigned n_out);
      return reg_addr_t'(n_out + 2);
   endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
   import pwm_chan_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned NUM_OUT = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en_i,
   input  reg_addr_t                       wr_addr_i,
   input  logic [CNT_W-1:0]                wr_data_i,
   input  logic [NUM_OUT:0]                hit_i,
   output logic [CNT_W-1:0]                period_o,
   output logic [NUM_OUT-1:0][CNT_W-1:0]   duty_o,
   output logic [NUM_OUT-1:0]              en_o,
   output logic [NUM_OUT-1:0]              pol_o,
   output logic [NUM_OUT-1:0]              init_o,
   output logic [NUM_OUT:0]                flag_o
);
   localparam reg_addr_t CTRL_A = ctrl_addr(NUM_OUT);
   localparam reg_addr_t FLAG_A = flag_addr(NUM_OUT);
   localparam int unsigned FW   = NUM_OUT + 1;

   logic [FW-1:0] keep_mask;

   always_comb begin
      keep_mask = '1;
      if (wr_en_i && wr_addr_i == FLAG_A)
         keep_mask = wr_data_i[FW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_o <= '1;
         duty_o   <= '1;
         en_o     <= '0;
         pol_o    <= '0;
         init_o   <= '0;
      end else if (wr_en_i) begin
         if (wr_addr_i == ADDR_PERIOD)
            period_o <= wr_data_i;
         for (int i = 0; i < NUM_OUT; i++) begin
            if (wr_addr_i == duty_addr(i))
               duty_o[i] <= wr_data_i;
         end
         if (wr_addr_i == CTRL_A) begin
            en_o   <= wr_data_i[NUM_OUT-1:0];
            pol_o  <= wr_data_i[2*NUM_OUT-1:NUM_OUT];
            init_o <= wr_data_i[3*NUM_OUT-1:2*NUM_OUT];
         end
      end
   end

   // hardware set takes precedence over a software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_o <= '0;
      else
         flag_o <= (flag_o & keep_mask) | hit_i;
   end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] period_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             restart_o,
   output logic             adv_o,
   output logic             wrap_o
);
   logic start_q;

   assign restart_o = start_i & ~start_q;
   assign adv_o     = start_i & start_q & tick_i;
   assign wrap_o    = adv_o & (cnt_o == period_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         cnt_o   <= '0;
      end else begin
         start_q <= start_i;
         if (restart_o || wrap_o)
            cnt_o <= '0;
         else if (adv_o)
            cnt_o <= cnt_o + CNT_W'(1);
      end
   end

endmodule

// File: rtl/pwm_outgen.sv
module pwm_outgen #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             adv_i,
   input  logic             wrap_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] duty_i,
   input  logic             pol_i,
   input  logic             init_i,
   input  logic             en_i,
   output logic             pin_o,
   output logic             oe_o,
   output logic             hit_o
);
   logic active_q;

   assign hit_o = adv_i & (cnt_i == duty_i);
   assign pin_o = ~(active_q ^ pol_i);
   assign oe_o  = en_i;

   // period match has priority, so a duty at or above the period never toggles
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         active_q <= 1'b0;
      else if (restart_i || wrap_i)
         active_q <= init_i;
      else if (hit_o)
         active_q <= ~init_i;
   end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
   import pwm_chan_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned NUM_OUT = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               cnt_en_i,
   input  logic               wr_en_i,
   input  logic [3:0]         wr_addr_i,
   input  logic [CNT_W-1:0]   wr_data_i,
   output logic [NUM_OUT-1:0] pwm_o,
   output logic [NUM_OUT-1:0] pwm_oe_o,
   output logic [NUM_OUT:0]   flag_o,
   output logic [CNT_W-1:0]   cnt_o
);
   if (NUM_OUT < 1 || NUM_OUT > 13) begin : g_bad_num_out
      $error("pwm_chan: NUM_OUT must lie in 1..13");
   end
   if (CNT_W < 3 * NUM_OUT || CNT_W < NUM_OUT + 1) begin : g_bad_cnt_w
      $error("pwm_chan: CNT_W too narrow for control and flag words");
   end

   logic [CNT_W-1:0]              period_q;
   logic [NUM_OUT-1:0][CNT_W-1:0] duty_q;
   logic [NUM_OUT-1:0]            en_q, pol_q, init_q;
   logic [NUM_OUT:0]              hit;
   logic                          restart, cnt_adv, wrap;

   pwm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .tick_i    (cnt_en_i),
      .period_i  (period_q),
      .cnt_o     (cnt_o),
      .restart_o (restart),
      .adv_o     (cnt_adv),
      .wrap_o    (wrap)
   );

   pwm_regs #(.CNT_W(CNT_W), .NUM_OUT(NUM_OUT)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .hit_i     (hit),
      .period_o  (period_q),
      .duty_o    (duty_q),
      .en_o      (en_q),
      .pol_o     (pol_q),
      .init_o    (init_q),
      .flag_o    (flag_o)
   );

   assign hit[0] = wrap;

   for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
      pwm_outgen #(.CNT_W(CNT_W)) u_og (
         .clk       (clk),
         .rst_n     (rst_n),
         .restart_i (restart),
         .adv_i     (cnt_adv),
         .wrap_i    (wrap),
         .cnt_i     (cnt_o),
         .duty_i    (duty_q[g]),
         .pol_i     (pol_q[g]),
         .init_i    (init_q[g]),
         .en_i      (en_q[g]),
         .pin_o     (pwm_o[g]),
         .oe_o      (pwm_oe_o[g]),
         .hit_o     (hit[g+1])
      );
   end

endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk
   import pwm_chan_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned NUM_OUT = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start_i,
   input logic               wr_en_i,
   input logic [3:0]         wr_addr_i,
   input logic [NUM_OUT-1:0] wr_en_bits,
   input logic               cnt_adv,
   input logic [CNT_W-1:0]   period_q,
   input logic [CNT_W-1:0]   cnt_o,
   input logic [NUM_OUT:0]   flag_o,
   input logic [NUM_OUT-1:0] pwm_oe_o
);
   localparam reg_addr_t CTRL_A = ctrl_addr(NUM_OUT);
   localparam reg_addr_t FLAG_A = flag_addr(NUM_OUT);

   p_hold_when_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(cnt_o));

   p_step_by_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_adv && cnt_o != period_q) |=> cnt_o == $past(cnt_o) + CNT_W'(1));

   p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_adv && cnt_o == period_q) |=> cnt_o == '0);

   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && wr_addr_i == FLAG_A) |=> ((flag_o & $past(flag_o)) == $past(flag_o)));

   p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_adv && cnt_o == period_q) |=> flag_o[0]);

   p_oe_follows_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i == CTRL_A) |=> pwm_oe_o == $past(wr_en_bits));

   p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_i) |=> cnt_o == '0);

endmodule

bind pwm_chan pwm_chan_chk #(.CNT_W(CNT_W), .NUM_OUT(NUM_OUT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .wr_en_i    (wr_en_i),
   .wr_addr_i  (wr_addr_i),
   .wr_en_bits (wr_data_i[NUM_OUT-1:0]),
   .cnt_adv    (cnt_adv),
   .period_q   (period_q),
   .cnt_o      (cnt_o),
   .flag_o     (flag_o),
   .pwm_oe_o   (pwm_oe_o)
);

// File: tb/pwm_chan_tb.sv
module pwm_chan_tb_top;
   localparam int CNT_W   = 16;
   localparam int NUM_OUT = 3;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start_i = 1'b0;
   logic               cnt_en_i = 1'b0;
   logic               wr_en_i = 1'b0;
   logic [3:0]         wr_addr_i = '0;
   logic [CNT_W-1:0]   wr_data_i = '0;
   logic [NUM_OUT-1:0] pwm_o;
   logic [NUM_OUT-1:0] pwm_oe_o;
   logic [NUM_OUT:0]   flag_o;
   logic [CNT_W-1:0]   cnt_o;

   int n_checks = 0;
   int n_fails  = 0;

   always #5 clk = ~clk;

   pwm_chan #(.CNT_W(CNT_W), .NUM_OUT(NUM_OUT)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cnt_en_i(cnt_en_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o), .flag_o(flag_o), .cnt_o(cnt_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic reg_wr(input logic [3:0] a, input logic [CNT_W-1:0] d);
      wr_en_i   = 1'b1;
      wr_addr_i = a;
      wr_data_i = d;
      @(negedge clk);
      wr_en_i   = 1'b0;
   endtask

   // restart and run one full period plus the wrap tick, checking every pin
   task automatic run_period(input int m, input int n [NUM_OUT],
                             input logic [NUM_OUT-1:0] pol,
                             input logic [NUM_OUT-1:0] init, input string req);
      start_i = 1'b0;
      @(negedge clk);
      start_i  = 1'b1;
      cnt_en_i = 1'b1;
      for (int k = 0; k <= m + 1; k++) begin
         @(negedge clk);
         chk({req, " R2 count"}, cnt_o, (k <= m) ? k : 0);
         for (int i = 0; i < NUM_OUT; i++) begin
            logic s_lvl, e_lvl;
            s_lvl = init[i] ? pol[i] : ~pol[i];
            e_lvl = (k <= m && k > n[i] && n[i] < m) ? ~s_lvl : s_lvl;
            chk(req, pwm_o[i], e_lvl);
         end
      end
      cnt_en_i = 1'b0;
   endtask

   task automatic t_reset;
      chk("R11 counter", cnt_o, 0);
      chk("R11 flags", flag_o, 0);
      chk("R11 oe", pwm_oe_o, 0);
   endtask

   task automatic t_basic_wave;
      int n [NUM_OUT];
      n = '{2, 0, 7};
      reg_wr(4'd0, 16'd5);
      reg_wr(4'd1, 16'd2);
      reg_wr(4'd2, 16'd0);
      reg_wr(4'd3, 16'd7);
      reg_wr(4'd4, 16'h012F); // en 111, pol 101, init 100
      chk("R9 oe all on", pwm_oe_o, 3'b111);
      run_period(5, n, 3'b101, 3'b100, "R3 R4 R5 R6 wave");
      chk("R7 flags after period", flag_o, 4'b0111);
   endtask

   task automatic t_flag_clear;
      reg_wr(4'd5, 16'h000D);
      chk("R7 clear bit1", flag_o, 4'b0101);
      reg_wr(4'd5, 16'h000F);
      chk("R7 write ones no effect", flag_o, 4'b0101);
   endtask

   task automatic t_gating;
      repeat (5) @(negedge clk);
      chk("R1 hold without tick", cnt_o, 0);
      cnt_en_i = 1'b1;
      repeat (3) @(negedge clk);
      cnt_en_i = 1'b0;
      chk("R1 three ticks", cnt_o, 3);
      repeat (2) @(negedge clk);
      chk("R1 hold after ticks", cnt_o, 3);
   endtask

   task automatic t_set_wins;
      cnt_en_i = 1'b1;
      repeat (2) @(negedge clk);
      chk("R8 pre count", cnt_o, 5);
      wr_en_i   = 1'b1;
      wr_addr_i = 4'd5;
      wr_data_i = '0;
      @(negedge clk);
      wr_en_i  = 1'b0;
      cnt_en_i = 1'b0;
      chk("R8 set beats clear", flag_o, 4'b0001);
      chk("R2 wrap", cnt_o, 0);
   endtask

   task automatic t_restart;
      cnt_en_i = 1'b1;
      repeat (3) @(negedge clk);
      cnt_en_i = 1'b0;
      chk("R3 mid pins", pwm_o, 3'b101);
      start_i  = 1'b0;
      cnt_en_i = 1'b1;
      @(negedge clk);
      chk("R1 stopped hold", cnt_o, 3);
      cnt_en_i = 1'b0;
      start_i  = 1'b1;
      @(negedge clk);
      chk("R10 counter zero", cnt_o, 0);
      chk("R10 start levels", pwm_o, 3'b110);
   endtask

   task automatic t_ctrl_change;
      reg_wr(4'd4, 16'h0112); // en 010, pol 010, init 100
      chk("R9 oe subset", pwm_oe_o, 3'b010);
      chk("R4 polarity flip", pwm_o, 3'b001);
   endtask

   task automatic t_duty_edges;
      int n [NUM_OUT];
      n = '{5, 1, 9};
      reg_wr(4'd1, 16'd5);
      reg_wr(4'd2, 16'd1);
      reg_wr(4'd3, 16'd9);
      reg_wr(4'd4, 16'h003F); // en 111, pol 111, init 000
      run_period(5, n, 3'b111, 3'b000, "R6 duty at or above period");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic_wave();
      t_flag_clear();
      t_gating();
      t_set_wins();
      t_restart();
      t_ctrl_change();
      t_duty_edges();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      #2000000;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule